// File: doc/BRIEF.md
# Layer Pixel Unpacker

This block sits between the memory fetch of one overlay layer and the compositor. It accepts 32-bit words over a valid/ready stream and emits 32-bit ARGB pixels (alpha in bits 31:24, red 23:16, green 15:8, blue 7:0) over a second valid/ready stream. A layer control word, held steady while data flows, decides how each word is read.

Two storage formats are decoded. The 32-bit format gives one pixel per word. The 16-bit 5-6-5 format gives two pixels per word, and each is widened to 8 bits per channel. Two independent controls adapt other memory layouts to the core ARGB order: a full reversal of the four bytes of the word, and an exchange of the red and blue channels. Combining them covers layers stored as BGRA (reversal only), RGBA (both) and ABGR, XBGR or BGR565 (exchange only). Any other format code on an enabled layer marks the layer unsupported, and its words are swallowed.

Top module: `lyr_unpack_top`

## Requirements
- R1: Bit 0 of `layer_ctrl` enables the layer; while it is 0, `word_ready` is 1, every offered word is consumed and no pixel appears on `pix_valid`.
- R2: Format field `layer_ctrl[6:4]` = 3 selects 32-bit ARGB: each accepted word yields exactly one pixel, equal to the word after the controls of R5 and R6.
- R3: Format field = 4 selects RGB565: each accepted word yields two pixels, first from bits 15:0, then from bits 31:16 (after the reversal of R5), with red in halfword bits 15:11, green 10:5, blue 4:0.
- R4: In RGB565 mode each channel is widened by copying its top bits into the freed low bits (red/blue: {c5, c5[4:2]}, green: {c6, c6[5:4]}) and alpha is 0xFF.
- R5: `layer_ctrl[8]` = 1 reverses the byte order of the input word (byte 0 becomes byte 3) before any other step; 0 keeps it.
- R6: `layer_ctrl[10]` = 1 exchanges output bits 23:16 and 7:0 (red and blue), applied after the byte reversal and the 565 widening.
- R7: With the layer enabled and a format code other than 3 or 4, `fmt_unsupported` is 1, words are consumed and dropped, and no pixel is produced; `fmt_unsupported` is 0 when the layer is disabled or the format is supported.
- R8: While `pix_valid` is 1 and `pix_ready` is 0, `pix_valid` stays 1 and `pix_argb` holds its value; no pixel is lost or repeated.
- R9: After synchronous reset `pix_valid` is 0.
- R10: In 32-bit mode with `pix_ready` held at 1, one word is accepted and one pixel delivered every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| layer_ctrl | input | 32 | Layer control word: enable, format, byte order, red/blue exchange |
| word_valid | input | 1 | Input word is offered |
| word_ready | output | 1 | Input word is taken this cycle |
| word_data | input | 32 | Fetched memory word |
| pix_valid | output | 1 | Output pixel is offered |
| pix_ready | input | 1 | Consumer takes the pixel this cycle |
| pix_argb | output | 32 | Pixel in ARGB8888 order |
| fmt_unsupported | output | 1 | Enabled layer uses a format the block cannot decode |

## Verification
Every combination of enable, all eight format codes, byte reversal and red/blue exchange is swept, each with a run of words whose bytes all differ, so a swapped, misplaced or duplicated byte shows as a mismatch against an arithmetic model. The 565 runs separate the halfword order and the bit replication of each channel; the drop configurations separate a disabled layer from an unsupported format through the flag and the silent output. Irregular stalls on both streams test that held pixels stay stable and that none are lost, and a gap-free run in 32-bit mode tests full rate.

// File: rtl/lyr_unpack_pkg.sv
package lyr_unpack_pkg;

    localparam int WORD_W   = 32;
    localparam int PIX_W    = 32;
    localparam int CTRL_W   = 32;
    localparam int HALF_W   = 16;
    localparam int HALVES   = WORD_W / HALF_W;
    localparam int BYTES    = WORD_W / 8;
    localparam int PH_W     = $clog2(HALVES + 1);
    localparam int IDX_W    = (HALVES > 1) ? $clog2(HALVES) : 1;

    // control word field positions (decoded by the fetch side as well)
    localparam int EN_BIT    = 0;
    localparam int FMT_LSB   = 4;
    localparam int FMT_W     = 3;
    localparam int ORDER_BIT = 8;
    localparam int SWAP_BIT  = 10;

    localparam logic [FMT_W-1:0] FMT_CODE_ARGB = 3'd3;
    localparam logic [FMT_W-1:0] FMT_CODE_565  = 3'd4;

    typedef enum logic [1:0] {
        MODE_DROP = 2'd0,
        MODE_ARGB = 2'd1,
        MODE_565  = 2'd2
    } lyr_mode_e;

    typedef struct packed {
        lyr_mode_e mode;
        logic      rev;
        logic      swap;
        logic      unsup;
    } lyr_cfg_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              is565;
        logic              swap;
        logic [PH_W-1:0]   npix;
    } lyr_held_t;

    function automatic logic [WORD_W-1:0] byte_reverse(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < BYTES; b++) begin
            r[8*b +: 8] = w[8*(BYTES-1-b) +: 8];
        end
        return r;
    endfunction

    function automatic logic [PIX_W-1:0] rb_exchange(input logic [PIX_W-1:0] p);
        return {p[31:24], p[7:0], p[15:8], p[23:16]};
    endfunction

    function automatic logic [PIX_W-1:0] widen565(input logic [HALF_W-1:0] h);
        return {8'hFF,
                h[15:11], h[15:13],
                h[10:5],  h[10:9],
                h[4:0],   h[4:2]};
    endfunction

endpackage

// File: rtl/lyr_cfg_decode.sv
module lyr_cfg_decode
    import lyr_unpack_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output lyr_cfg_t          cfg
);
    logic [FMT_W-1:0] fmt;
    logic             en;
    logic             ctrl_unused;

    assign fmt = ctrl[FMT_LSB +: FMT_W];
    assign en  = ctrl[EN_BIT];
    // bits that carry no meaning for this datapath
    assign ctrl_unused = ^{ctrl[CTRL_W-1:SWAP_BIT+1], ctrl[ORDER_BIT+1],
                           ctrl[FMT_LSB+FMT_W], ctrl[FMT_LSB-1:EN_BIT+1]};

    always_comb begin
        cfg.rev   = ctrl[ORDER_BIT];
        cfg.swap  = ctrl[SWAP_BIT];
        cfg.unsup = 1'b0;
        cfg.mode  = MODE_DROP;
        if (en) begin
            if (fmt == FMT_CODE_ARGB) begin
                cfg.mode = MODE_ARGB;
            end else if (fmt == FMT_CODE_565) begin
                cfg.mode = MODE_565;
            end else begin
                cfg.unsup = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lyr_word_hold.sv
module lyr_word_hold
    import lyr_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lyr_cfg_t          cfg,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              out_ready,
    output logic              held_valid,
    output lyr_held_t         held,
    output logic [PH_W-1:0]   phase
);
    logic      last;
    logic      drop;
    logic      load;
    lyr_held_t next_held;

    assign drop     = (cfg.mode == MODE_DROP);
    assign last     = (phase == held.npix - 1'b1);
    assign in_ready = drop || !held_valid || (out_ready && last);
    assign load     = in_valid && in_ready && !drop;

    always_comb begin
        next_held.word  = cfg.rev ? byte_reverse(in_data) : in_data;
        next_held.is565 = (cfg.mode == MODE_565);
        next_held.swap  = cfg.swap;
        next_held.npix  = (cfg.mode == MODE_565) ? PH_W'(HALVES) : PH_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            phase      <= '0;
            held       <= '0;
        end else begin
            if (held_valid && out_ready) begin
                if (last) begin
                    held_valid <= 1'b0;
                    phase      <= '0;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
            if (load) begin
                held_valid <= 1'b1;
                phase      <= '0;
                held       <= next_held;
            end
        end
    end

    // R8: a stalled word and its pixel index stay put
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        held_valid && !out_ready |=> held_valid && $stable(held) && $stable(phase));

    // R3: the first half of a 565 word is always followed by the second
    p_second_half_r3: assert property (@(posedge clk) disable iff (rst)
        held_valid && out_ready && !last |=> held_valid && (phase != '0));

endmodule

// File: rtl/lyr_pix_format.sv
module lyr_pix_format
    import lyr_unpack_pkg::*;
(
    input  lyr_held_t        held,
    input  logic [PH_W-1:0]  phase,
    output logic [PIX_W-1:0] pixel
);
    logic [PIX_W-1:0] cand [HALVES];
    logic [PIX_W-1:0] base;
    logic [IDX_W-1:0] sel;

    genvar h;
    generate
        for (h = 0; h < HALVES; h++) begin : g_half
            assign cand[h] = widen565(held.word[HALF_W*h +: HALF_W]);
        end
    endgenerate

    assign sel   = phase[IDX_W-1:0];
    assign base  = held.is565 ? cand[sel] : held.word;
    assign pixel = held.swap ? rb_exchange(base) : base;
endmodule

// File: rtl/lyr_unpack_top.sv
module lyr_unpack_top
    import lyr_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] layer_ctrl,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [PIX_W-1:0]  pix_argb,
    output logic              fmt_unsupported
);
    lyr_cfg_t        cfg;
    lyr_held_t       held;
    logic [PH_W-1:0] phase;

    lyr_cfg_decode i_dec (
        .ctrl (layer_ctrl),
        .cfg  (cfg)
    );

    lyr_word_hold i_hold (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .in_valid   (word_valid),
        .in_ready   (word_ready),
        .in_data    (word_data),
        .out_ready  (pix_ready),
        .held_valid (pix_valid),
        .held       (held),
        .phase      (phase)
    );

    lyr_pix_format i_fmt (
        .held  (held),
        .phase (phase),
        .pixel (pix_argb)
    );

    assign fmt_unsupported = cfg.unsup;

    // R8: the offered pixel does not change while stalled
    p_pix_stable_r8: assert property (@(posedge clk) disable iff (rst)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_argb));

    // R1 / R7: an idle output stays idle while the layer drops words
    p_drop_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_DROP) && !pix_valid |=> !pix_valid);

    // R7: an unsupported layer never stalls the fetch side
    p_unsup_drains_r7: assert property (@(posedge clk) disable iff (rst)
        fmt_unsupported |-> word_ready);

    // R4: every 565 pixel is opaque
    p_opaque_565_r4: assert property (@(posedge clk) disable iff (rst)
        pix_valid && held.is565 |-> pix_argb[31:24] == 8'hFF);

endmodule

// File: tb/test_lyr_unpack_top.sv
module test_lyr_unpack_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] layer_ctrl = '0;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic [31:0] word_data = '0;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic [31:0] pix_argb;
    logic        fmt_unsupported;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] expq [$];

    always #5 clk = ~clk;

    lyr_unpack_top i_lyr_unpack_top (
        .clk             (clk),
        .rst             (rst),
        .layer_ctrl      (layer_ctrl),
        .word_valid      (word_valid),
        .word_ready      (word_ready),
        .word_data       (word_data),
        .pix_valid       (pix_valid),
        .pix_ready       (pix_ready),
        .pix_argb        (pix_argb),
        .fmt_unsupported (fmt_unsupported)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] m_swap(input logic [31:0] p);
        return {p[31:24], p[7:0], p[15:8], p[23:16]};
    endfunction

    function automatic logic [31:0] m_565(input logic [15:0] h);
        int r = h[15:11];
        int g = h[10:5];
        int b = h[4:0];
        int r8 = r * 8 + r / 4;
        int g8 = g * 4 + g / 16;
        int b8 = b * 8 + b / 4;
        return {8'hFF, r8[7:0], g8[7:0], b8[7:0]};
    endfunction

    task automatic push_expected(input logic [31:0] d, input bit is565, input bit rev, input bit sw);
        logic [31:0] w = rev ? m_rev(d) : d;
        if (is565) begin
            for (int h = 0; h < 2; h++) begin
                logic [31:0] p = m_565(w[16*h +: 16]);
                expq.push_back(sw ? m_swap(p) : p);
            end
        end else begin
            expq.push_back(sw ? m_swap(w) : w);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cyc = 0;
        repeat (3) @(negedge clk);
        check(pix_valid == 1'b0, "R9 reset", {31'd0, pix_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(pix_valid == 1'b0, "R9 after reset", {31'd0, pix_valid}, 32'd0);

        for (int cfg = 0; cfg < 64; cfg++) begin
            bit en  = cfg[0];
            int fmt = cfg[3:1];
            bit rev = cfg[4];
            bit sw  = cfg[5];
            bit sup = en && (fmt == 3 || fmt == 4);
            bit is565 = (fmt == 4);
            string tag;
            int sent = 0;
            bit prev_stall = 0;
            logic [31:0] prev_pix = '0;
            if (!en)        tag = "R1";
            else if (!sup)  tag = "R7";
            else if (is565) tag = "R3 R4";
            else            tag = "R2";
            if (rev) tag = {tag, " R5"};
            if (sw)  tag = {tag, " R6"};

            layer_ctrl = {21'd0, sw, 1'b0, rev, 1'b0, fmt[2:0], 3'd0, en};
            #1;
            check(fmt_unsupported == (en && !sup), "R7 flag", {31'd0, fmt_unsupported},
                  {31'd0, en && !sup});

            for (int k = 0; k < 80; k++) begin
                @(negedge clk);
                cyc++;
                word_valid = (sent < 5) && ((cyc % 3) != 2);
                word_data  = (sent + 1) * 32'h9E3779B1 ^ (cfg * 32'h01010101);
                pix_ready  = ((cyc * 5 + cfg) % 4) != 0;
                #1;
                if (prev_stall) begin
                    check(pix_valid && pix_argb == prev_pix, "R8 stall hold", pix_argb, prev_pix);
                end
                if (pix_valid && pix_ready) begin
                    if (expq.size() == 0) begin
                        check(1'b0, tag, pix_argb, 32'hXXXXXXXX);
                    end else begin
                        logic [31:0] e = expq.pop_front();
                        check(pix_argb == e, tag, pix_argb, e);
                    end
                end
                if (word_valid && word_ready) begin
                    sent++;
                    if (sup) push_expected(word_data, is565, rev, sw);
                end
                prev_stall = pix_valid && !pix_ready;
                prev_pix   = pix_argb;
                if (sent == 5 && expq.size() == 0 && !pix_valid) break;
            end
            word_valid = 1'b0;
            check(sent == 5 && expq.size() == 0, {tag, " drained"}, expq.size(), 32'd0);
            expq.delete();
        end

        // R10: full rate in 32-bit mode
        begin
            int acc = 0;
            int outs = 0;
            layer_ctrl = 32'h0000_0031;
            pix_ready  = 1'b1;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                word_valid = 1'b1;
                word_data  = 32'hA5000000 + k;
                #1;
                if (pix_valid) begin
                    check(pix_argb == 32'hA5000000 + k - 1, "R10 data", pix_argb, 32'hA5000000 + k - 1);
                    outs++;
                end
                if (word_ready) acc++;
            end
            check(acc == 10, "R10 accepts", acc, 10);
            check(outs == 9, "R10 pixels", outs, 9);
            @(negedge clk);
            word_valid = 1'b0;
            repeat (2) @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule